// File: doc/BRIEF.md
# Slot Reset and Clock-Enable Sequencer

This block sequences the reset line of one card slot together with a shared open-drain clock-enable line. It watches one combined flag that says all supply rails of the slot are in tolerance. While any rail is bad, it pulls the clock-enable line low. Once the rails are good, it lets the line go. The host, or any other agent on the line, may keep the line low for as long as it likes.

The timer that releases the slot reset does not start when power becomes good. It starts when the synchronized clock-enable line is seen to rise. The host can also drop its system-reset input to reset the card without touching the rails (a warm reset). That input acts on the slot reset only and never on the clock-enable line.

Every reset pulse has a guaranteed minimum width. Both the release delay and the minimum width are parameters counted in clock cycles. The design default is 10 ms of delay and 250 µs of width at 100 MHz.

Top module: `slot_rst_seq`

## Requirements
- R1: During and right after the synchronous reset `rst`, `slot_rst_n_o` is 0 and `clken_pd_o` is 1 (pull-down active).
- R2: `clken_pd_o` becomes 1 one cycle after `rails_ok_i` is sampled 0, and becomes 0 one cycle after it is sampled 1. `host_rst_n_i` never changes it.
- R3: When `rails_ok_i` is sampled 0, `slot_rst_n_o` is 0 on the next cycle.
- R4: `clken_pin_i` passes through a two-flop synchronizer. The delay timer starts at the edge after the synchronized level is first seen high, which is the edge two cycles after the first edge that samples the pin high. `slot_rst_n_o` rises HOLD_CYC cycles after that start edge.
- R5: While `clken_pin_i` is held low by an external agent, `slot_rst_n_o` stays 0 no matter how long the rails have been good.
- R6: When `host_rst_n_i` is sampled 0, `slot_rst_n_o` is 0 on the next cycle.
- R7: After `host_rst_n_i` returns to 1 with rails good and the line high, the timer restarts from zero at the first edge that samples it high. Release follows HOLD_CYC cycles later.
- R8: `slot_rst_n_o` never rises fewer than MIN_LOW_CYC cycles after its falling edge. When the timer ends first, release waits for this width.
- R9: A new reset cause while the timer runs clears the timer. The full HOLD_CYC delay is then counted again from the next start.
- R10: After a rail failure, the timer needs a fresh low-to-high transition of the synchronized line. A stale high left in the synchronizer does not start it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rails_ok_i | input | 1 | 1 when all slot rails are within tolerance |
| host_rst_n_i | input | 1 | Host system reset, active low |
| clken_pin_i | input | 1 | Sensed level of the shared clock-enable line |
| clken_pd_o | output | 1 | 1 turns on the open-drain pull-down of the clock-enable line |
| slot_rst_n_o | output | 1 | Slot reset to the card, active low |

## Verification
A rail failure or host reset shows on `slot_rst_n_o` one cycle after the sampling edge, and a rail change shows on `clken_pd_o` one cycle after it. A released clock-enable line reaches the FSM three edges after the pin first reads high. Release then comes HOLD_CYC edges after that start edge, or MIN_LOW_CYC edges after the fall, whichever is later. For each stimulus the bench computes these edge numbers and queues an expected pair of output values for the cycle just before release and for the release cycle itself. The monitor samples both outputs at the falling edge that follows the numbered rising edge, so a release that comes one cycle early or late fails.

// File: rtl/slot_rst_pkg.sv
package slot_rst_pkg;

    typedef enum logic [1:0] {
        SEQ_WAIT  = 2'd0,
        SEQ_COUNT = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic rail_bad;
        logic host_rst;
    } rst_cause_t;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

    function automatic logic any_cause(input rst_cause_t c);
        return c.rail_bad | c.host_rst;
    endfunction

endpackage

// File: rtl/slot_rst_sync.sv
module slot_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/slot_rst_satcnt.sv
module slot_rst_satcnt
    import slot_rst_pkg::*;
#(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int unsigned     CW   = cnt_width(LIMIT);
    localparam logic [CW-1:0]   LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)             cnt <= '0;
        else if (en && cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LAST);
endmodule

// File: rtl/slot_rst_seq.sv
module slot_rst_seq
    import slot_rst_pkg::*;
#(
    parameter int unsigned HOLD_CYC    = 1_000_000,
    parameter int unsigned MIN_LOW_CYC = 25_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rails_ok_i,
    input  logic host_rst_n_i,
    input  logic clken_pin_i,
    output logic clken_pd_o,
    output logic slot_rst_n_o
);
    seq_state_e state_q, state_d;
    rst_cause_t cause;
    logic       pin_sync, pin_prev, pin_rise, need_edge_q;
    logic       start, dly_done, low_done;
    logic       rst_n_q, rst_n_d, pd_q;

    slot_rst_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i (clken_pin_i),
        .q_o (pin_sync)
    );

    // hold-off timer: cleared whenever not counting
    slot_rst_satcnt #(.LIMIT(HOLD_CYC)) dly_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (state_q != SEQ_COUNT),
        .en   (state_q == SEQ_COUNT),
        .done (dly_done)
    );

    // minimum-width timer: runs while the slot reset is low
    slot_rst_satcnt #(.LIMIT(MIN_LOW_CYC)) low_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (rst_n_q),
        .en   (1'b1),
        .done (low_done)
    );

    always_comb begin
        cause.rail_bad = ~rails_ok_i;
        cause.host_rst = ~host_rst_n_i;
    end

    assign pin_rise = pin_sync & ~pin_prev;
    assign start    = pin_sync & (~need_edge_q | pin_rise);

    always_comb begin
        state_d = state_q;
        rst_n_d = rst_n_q;
        if (any_cause(cause)) begin
            state_d = SEQ_WAIT;
            rst_n_d = 1'b0;
        end else begin
            unique case (state_q)
                SEQ_WAIT:  if (start) state_d = SEQ_COUNT;
                SEQ_COUNT: if (dly_done && low_done) begin
                    state_d = SEQ_RUN;
                    rst_n_d = 1'b1;
                end
                SEQ_RUN:   state_d = SEQ_RUN;
                default:   state_d = SEQ_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SEQ_WAIT;
            rst_n_q     <= 1'b0;
            pd_q        <= 1'b1;
            pin_prev    <= 1'b0;
            need_edge_q <= 1'b1;
        end else begin
            state_q  <= state_d;
            rst_n_q  <= rst_n_d;
            pd_q     <= cause.rail_bad;
            pin_prev <= pin_sync;
            if (cause.rail_bad)  need_edge_q <= 1'b1;
            else if (pin_rise)   need_edge_q <= 1'b0;
        end
    end

    assign clken_pd_o   = pd_q;
    assign slot_rst_n_o = rst_n_q;
endmodule

// File: rtl/slot_rst_seq_chk.sv
module slot_rst_seq_chk #(
    parameter int unsigned MIN_LOW_CYC = 25_000
) (
    input logic clk,
    input logic rst,
    input logic rails_ok_i,
    input logic host_rst_n_i,
    input logic clken_pin_i,
    input logic clken_pd_o,
    input logic slot_rst_n_o
);
    int unsigned low_run;

    always_ff @(posedge clk) begin
        if (rst)                         low_run <= 0;
        else if (slot_rst_n_o)           low_run <= 0;
        else if (low_run < MIN_LOW_CYC)  low_run <= low_run + 1;
    end

    AST_PD_ON_RAIL_BAD: assert property (@(posedge clk) disable iff (rst)
        !rails_ok_i |=> clken_pd_o); // R2
    AST_PD_OFF_RAIL_OK: assert property (@(posedge clk) disable iff (rst)
        rails_ok_i |=> !clken_pd_o); // R2
    AST_RAIL_FORCES_RST: assert property (@(posedge clk) disable iff (rst)
        !rails_ok_i |=> !slot_rst_n_o); // R3
    AST_HOST_FORCES_RST: assert property (@(posedge clk) disable iff (rst)
        !host_rst_n_i |=> !slot_rst_n_o); // R6
    AST_RELEASE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $rose(slot_rst_n_o) |-> ($past(rails_ok_i) && $past(host_rst_n_i) && $past(clken_pin_i))); // R4
    AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(slot_rst_n_o) |-> (low_run >= MIN_LOW_CYC)); // R8
endmodule

bind slot_rst_seq slot_rst_seq_chk #(.MIN_LOW_CYC(MIN_LOW_CYC)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .rails_ok_i   (rails_ok_i),
    .host_rst_n_i (host_rst_n_i),
    .clken_pin_i  (clken_pin_i),
    .clken_pd_o   (clken_pd_o),
    .slot_rst_n_o (slot_rst_n_o)
);

// File: tb/slot_rst_seq_tb.sv
module slot_rst_seq_tb_top;
    localparam int unsigned HOLD = 50;
    localparam int unsigned MINW = 80;

    typedef struct {
        int    cyc;
        logic  rst_n;
        logic  pd;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rails_ok = 1'b0;
    logic host_rst_n = 1'b1;
    logic ext_hold = 1'b0;
    logic clken_pin, clken_pd, slot_rst_n;

    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    exp_t q[$];
    exp_t item;

    always #2 clk = ~clk;

    assign clken_pin = ~clken_pd & ~ext_hold;

    slot_rst_seq #(.HOLD_CYC(HOLD), .MIN_LOW_CYC(MINW), .SYNC_STAGES(2)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .rails_ok_i   (rails_ok),
        .host_rst_n_i (host_rst_n),
        .clken_pin_i  (clken_pin),
        .clken_pd_o   (clken_pd),
        .slot_rst_n_o (slot_rst_n)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic report(input string req, input logic ar, input logic ap,
                          input logic er, input logic ep);
        checks++;
        if (ar !== er || ap !== ep) begin
            failures++;
            $display("FAIL %s cyc=%0d slot_rst_n=%b exp %b clken_pd=%b exp %b",
                     req, cyc, ar, er, ap, ep);
        end
    endtask

    task automatic expect_at(input int c, input logic r, input logic p, input string req);
        exp_t e;
        e.cyc = c; e.rst_n = r; e.pd = p; e.req = req;
        q.push_back(e);
    endtask

    // monitor: compares queued expectations in their cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            item = q.pop_front();
            if (item.cyc < cyc) begin
                checks++;
                failures++;
                $display("FAIL %s missed cycle %0d (now %0d) exp rst_n=%b",
                         item.req, item.cyc, cyc, item.rst_n);
            end else begin
                report(item.req, slot_rst_n, clken_pd, item.rst_n, item.pd);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 100000) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        step(3);
    endtask

    initial begin
        int k;
        step(3);
        report("R1 reset", slot_rst_n, clken_pd, 1'b0, 1'b1);
        rst = 1'b0;
        step(100);
        report("R1 after reset, rails bad", slot_rst_n, clken_pd, 1'b0, 1'b1);

        // power-up: pin rises after pull-down release, timer starts two edges later
        k = cyc; rails_ok = 1'b1;
        expect_at(k + 1,  1'b0, 1'b0, "R2 pd release");
        expect_at(k + 53, 1'b0, 1'b0, "R4 before delay");
        expect_at(k + 54, 1'b1, 1'b0, "R4 release");
        drain();

        // rail failure, then external hold of the clock-enable line
        k = cyc; rails_ok = 1'b0;
        expect_at(k + 1, 1'b0, 1'b1, "R3 rail drop");
        step(5);
        k = cyc; rails_ok = 1'b1; ext_hold = 1'b1;
        expect_at(k + 1,   1'b0, 1'b0, "R2 pd release with rails good");
        expect_at(k + 200, 1'b0, 1'b0, "R5 held off");
        step(210);
        k = cyc; ext_hold = 1'b0;
        expect_at(k + 52, 1'b0, 1'b0, "R4 before delay after hold");
        expect_at(k + 53, 1'b1, 1'b0, "R4 release after hold");
        drain();

        // short warm reset: minimum width dominates
        k = cyc; host_rst_n = 1'b0;
        expect_at(k + 1, 1'b0, 1'b0, "R6 warm reset, R2 pd unaffected");
        step(1); host_rst_n = 1'b1;
        expect_at(k + 80, 1'b0, 1'b0, "R8 before min width");
        expect_at(k + 81, 1'b1, 1'b0, "R8 release at min width");
        drain();

        // long warm reset: delay restarts from release of host reset
        k = cyc; host_rst_n = 1'b0;
        expect_at(k + 1, 1'b0, 1'b0, "R6 long warm reset");
        step(100); host_rst_n = 1'b1;
        expect_at(k + 150, 1'b0, 1'b0, "R7 before restarted delay");
        expect_at(k + 151, 1'b1, 1'b0, "R7 release");
        drain();

        // new cause during the delay clears the timer
        k = cyc; host_rst_n = 1'b0;
        step(1); host_rst_n = 1'b1;
        step(69); host_rst_n = 1'b0;
        step(1); host_rst_n = 1'b1;
        expect_at(k + 121, 1'b0, 1'b0, "R9 timer cleared");
        expect_at(k + 122, 1'b1, 1'b0, "R9 release after full delay");
        drain();

        // one-cycle rail glitch with stale high in the synchronizer
        k = cyc; rails_ok = 1'b0;
        expect_at(k + 1, 1'b0, 1'b1, "R3 glitch");
        step(1); rails_ok = 1'b1; ext_hold = 1'b1;
        expect_at(k + 2,   1'b0, 1'b0, "R2 glitch pd release");
        expect_at(k + 150, 1'b0, 1'b0, "R10 stale high ignored");
        step(159);
        k = cyc; ext_hold = 1'b0;
        expect_at(k + 52, 1'b0, 1'b0, "R10 before delay");
        expect_at(k + 53, 1'b1, 1'b0, "R10 release on fresh rise");
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule